// File: doc/BRIEF.md
# BSSID Mask Address Filter

This block decides whether a received frame belongs to the station, so that the receiver can acknowledge it. The frame's 48-bit BSSID is compared with the station's own MAC address. Only the bit positions set in a programmable 48-bit mask take part in the comparison. Because the unmasked positions are ignored, one MAC address can answer for several virtual BSSIDs. The price is that a foreign BSSID which agrees with the MAC on every masked bit is accepted as well.

Software computes the mask. It ANDs together NOT(MAC XOR BSSID) over every BSSID it serves, so the mask keeps only the bits that all of those BSSIDs share with the MAC. Software loads the mask and the MAC through a word-wide write port, each as a low 32-bit word and a high 16-bit word. A BSSID is presented with a valid strobe. One clock later the block returns a registered accept/reject result together with a one-cycle valid pulse.

The result stage is a two-state machine:
- `ST_IDLE` means no result is pending. It moves to `ST_REPORT` on a BSSID strobe and otherwise stays in `ST_IDLE`.
- `ST_REPORT` drives the result valid pulse. It stays in `ST_REPORT` when another strobe arrives in the same cycle (back-to-back compares) and otherwise returns to `ST_IDLE`.

Top module: `bssid_mask_filter`

## Requirements
- R1: A compare accepts exactly when ((bssid XOR mac) AND mask) is zero, and rejects otherwise.
- R2: A write to select 0 loads mask bits 47..0 positions 31:0 from wr_data[31:0], with byte 0 of the address in bits 7:0. A write to select 1 loads mask bits 47:32 from wr_data[15:0]. wr_data[31:16] is ignored for select 1.
- R3: Selects 2 and 3 load the MAC with the same split and byte order as the mask: select 2 loads bits 31:0 and select 3 loads bits 47:32 from wr_data[15:0].
- R4: After reset the mask is all ones and the MAC is zero, so only the BSSID of value zero is accepted. res_vld is low while reset is held.
- R5: With a mask of all ones, a BSSID differing from the MAC in any single bit is rejected and an equal BSSID is accepted.
- R6: res_vld pulses high in exactly the cycle after each cycle in which bssid_vld is high, and only then. Consecutive strobes yield consecutive results.
- R7: res_accept is low whenever res_vld is low.
- R8: A register write in the same cycle as a BSSID strobe does not affect that compare. It affects only later compares.
- R9: With MAC 0x1 and mask 0x2, the BSSIDs 0x1, 0x4, 0x9 and 0xD are accepted and 0x6 is rejected. A non-served BSSID that matches on all masked bits is accepted.
- R10: With a mask of zero, every BSSID is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mask low, 1 mask high, 2 MAC low, 3 MAC high |
| wr_data | input | 32 | Write data word |
| bssid_vld | input | 1 | BSSID valid strobe |
| bssid | input | 48 | Received BSSID, byte 0 in bits 7:0 |
| res_vld | output | 1 | Result valid pulse |
| res_accept | output | 1 | Accept (1) or reject (0), meaningful while res_vld is high |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe-to-result latency in both directions;
- the quiet accept output outside result cycles;
- that the mask holds without a write;
- that each result equals the masked comparison of the register contents and BSSID seen at the strobe.

Some behaviour can only be shown by the bench's scenarios:
- the mapping of write words and byte lanes onto the 48-bit registers, including the ignored upper half of the high word;
- the reset values as seen through compares;
- the worked multi-BSSID case;
- the ordering of a write against a compare in the same cycle.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
    localparam int ADDR_W     = 48;
    localparam int WORD_W     = 32;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int NUM_WORDS  = (ADDR_BYTES + WORD_BYTES - 1) / WORD_BYTES;
    localparam int SEL_W      = $clog2(2 * NUM_WORDS);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } bmf_state_e;
endpackage

// File: rtl/bmf_wordreg.sv
module bmf_wordreg #(
    parameter int ADDR_W     = 48,
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 2,
    parameter int SEL_W      = 2,
    parameter int BASE_SEL   = 0,
    parameter bit RESET_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] value
);
    // One register word per slice of the wide value; the last may be narrower.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int LO    = w * WORD_W;
        localparam int HI    = (LO + WORD_W > ADDR_W) ? ADDR_W - 1 : LO + WORD_W - 1;
        localparam int WIDTH = HI - LO + 1;

        logic [WIDTH-1:0] word_q;
        logic             hit;

        assign hit = wr_en && (wr_sel == SEL_W'(BASE_SEL + w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= {WIDTH{RESET_ONES}};
            end else if (hit) begin
                word_q <= wr_data[WIDTH-1:0];
            end
        end

        assign value[HI:LO] = word_q;
    end
endmodule

// File: rtl/bmf_match.sv
module bmf_match #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] bssid,
    input  logic [ADDR_W-1:0] mac,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    localparam int LANES = ADDR_W / 8;

    logic [LANES-1:0] lane_ok;

    // Each byte lane is compared independently on its selected bits.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] diff;
        assign diff       = (bssid[b*8 +: 8] ^ mac[b*8 +: 8]) & mask[b*8 +: 8];
        assign lane_ok[b] = (diff == 8'h00);
    end

    assign hit = &lane_ok;
endmodule

// File: rtl/bssid_mask_filter.sv
module bssid_mask_filter
    import bmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bssid_vld,
    input  logic [ADDR_W-1:0] bssid,
    output logic              res_vld,
    output logic              res_accept
);
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] mac_q;
    logic              match_hit;
    bmf_state_e        state_q;
    bmf_state_e        state_d;

    // Mask words sit at selects 0..NUM_WORDS-1 and reset to all ones.
    bmf_wordreg #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
        .SEL_W(SEL_W), .BASE_SEL(0), .RESET_ONES(1'b1)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .value(mask_q)
    );

    // MAC words follow the mask words and reset to zero.
    bmf_wordreg #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
        .SEL_W(SEL_W), .BASE_SEL(NUM_WORDS), .RESET_ONES(1'b0)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .value(mac_q)
    );

    // The comparison uses the register contents before any write in this cycle.
    bmf_match #(.ADDR_W(ADDR_W)) u_match (
        .bssid(bssid), .mac(mac_q), .mask(mask_q), .hit(match_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = bssid_vld ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = bssid_vld ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         res_accept <= 1'b0;
        else if (bssid_vld) res_accept <= match_hit;
        else                res_accept <= 1'b0;
    end

    assign res_vld = (state_q == ST_REPORT);
endmodule

// File: rtl/bmf_checker.sv
module bmf_checker
    import bmf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              bssid_vld,
    input logic [ADDR_W-1:0] bssid,
    input logic [ADDR_W-1:0] mask_q,
    input logic [ADDR_W-1:0] mac_q,
    input logic              res_vld,
    input logic              res_accept
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bssid_vld |=> res_vld); // R6

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !bssid_vld |=> !res_vld); // R6

    AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !res_accept); // R7

    AST_MASKED_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        bssid_vld |=> (res_accept == ($past(((bssid ^ mac_q) & mask_q)) == '0))); // R1

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R2
endmodule

bind bssid_mask_filter bmf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bssid_vld(bssid_vld),
    .bssid(bssid), .mask_q(mask_q), .mac_q(mac_q),
    .res_vld(res_vld), .res_accept(res_accept)
);

// File: tb/bssid_mask_filter_tb.sv
module bssid_mask_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        bssid_vld = 1'b0;
    logic [47:0] bssid = '0;
    logic        res_vld;
    logic        res_accept;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [47:0] m_mask = '1;
    logic [47:0] m_mac  = '0;

    always #4 clk = ~clk;

    bssid_mask_filter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bssid_vld(bssid_vld), .bssid(bssid),
        .res_vld(res_vld), .res_accept(res_accept)
    );

    function automatic bit expect_accept(input logic [47:0] b);
        return ((b ^ m_mac) & m_mask) == '0;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: vld/accept actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        if (sel == 2'd0) m_mask[31:0]  = data;
        if (sel == 2'd1) m_mask[47:32] = data[15:0];
        if (sel == 2'd2) m_mac[31:0]   = data;
        if (sel == 2'd3) m_mac[47:32]  = data[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic compare(input string req, input logic [47:0] b, input bit exp);
        @(negedge clk);
        bssid = b; bssid_vld = 1'b1;
        @(negedge clk);
        bssid_vld = 1'b0;
        check(req, {res_vld, res_accept}, {1'b1, exp});
        @(negedge clk);
        check(req, {res_vld, res_accept}, 2'b00);
    endtask

    task automatic t_reset();
        check("R4", {res_vld, res_accept}, 2'b00);
        compare("R4", 48'h0, 1'b1);
        compare("R4", 48'h0000_0100_0000, 1'b0);
    endtask

    task automatic t_exact();
        write_reg(2'd2, 32'h89AB_CDEF);
        write_reg(2'd3, 32'hFFFF_4567);
        compare("R5", 48'h4567_89AB_CDEF, 1'b1);
        for (int i = 0; i < 48; i += 7)
            compare("R5", 48'h4567_89AB_CDEF ^ (48'h1 << i), 1'b0);
        compare("R3", 48'hFFFF_89AB_CDEF, 1'b0);
    endtask

    task automatic t_mask_layout();
        write_reg(2'd0, 32'h0000_00FF);
        write_reg(2'd1, 32'hFFFF_0000);
        compare("R2", 48'hFFFF_FFFF_FFEF, 1'b1);
        compare("R2", 48'hFFFF_FFFF_FF00, 1'b0);
        write_reg(2'd1, 32'h0000_8000);
        compare("R2", 48'h4567_89AB_CDEF, 1'b1);
        compare("R2", 48'hC567_89AB_CDEF, 1'b0);
        compare("R1", 48'h4000_0000_00EF, 1'b1);
    endtask

    task automatic t_multi_bssid();
        write_reg(2'd2, 32'h0000_0001);
        write_reg(2'd3, 32'h0000_0000);
        write_reg(2'd0, 32'h0000_0002);
        write_reg(2'd1, 32'h0000_0000);
        compare("R9", 48'h1, 1'b1);
        compare("R9", 48'h4, 1'b1);
        compare("R9", 48'h9, 1'b1);
        compare("R9", 48'hD, 1'b1);
        compare("R9", 48'h6, 1'b0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        bssid = 48'h4; bssid_vld = 1'b1;
        @(negedge clk);
        check("R6", {res_vld, res_accept}, 2'b11);
        bssid = 48'h6;
        @(negedge clk);
        check("R6", {res_vld, res_accept}, 2'b10);
        bssid = 48'h1;
        @(negedge clk);
        bssid_vld = 1'b0;
        check("R6", {res_vld, res_accept}, 2'b11);
        @(negedge clk);
        check("R7", {res_vld, res_accept}, 2'b00);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_0000;
        bssid = 48'h6; bssid_vld = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bssid_vld = 1'b0;
        check("R8", {res_vld, res_accept}, 2'b10);
        m_mask[31:0] = 32'h0;
        compare("R8", 48'h6, 1'b1);
    endtask

    task automatic t_zero_mask();
        write_reg(2'd1, 32'h0000_0000);
        compare("R10", 48'hFFFF_FFFF_FFFF, 1'b1);
        compare("R10", 48'h1234_5678_9ABC, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_mask_layout();
        t_multi_bssid();
        t_back_to_back();
        t_same_cycle();
        t_zero_mask();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule